// File: doc/BRIEF.md
# I2C Bus Clock and Data-Timing Generator

This block paces the bus side of an I2C master. It drives SCL low for a programmed low phase, releases it, waits until the line is actually seen high, and then holds it released for a programmed high phase. Inside each low phase it tells the data shifter when SDA may change, which is after a programmed hold time. It keeps SCL low until a programmed setup time has passed since that change. All timing comes from one packed 32-bit word together with a digital filter length. Software computes both values. The kernel clock is first divided by a prescaler, and the other fields count in those prescaled ticks.

SCL and SDA from the pads each pass through a glitch filter. The filtered SCL decides when the high phase may start, so a slave that holds SCL low stretches the clock and is never overridden. The filter delay plus two kernel clocks is added to each SCL phase as a synchronisation allowance.

The state machine has four named states:
- `ST_IDLE`: both lines released; the timing word and filter length are captured every cycle.
- `ST_LOW`: SCL is driven low.
- `ST_WAIT_HI`: SCL is released and the block waits for the filtered line to be high.
- `ST_HIGH`: the high-phase count runs.

Its transitions are:
- *start*: `ST_IDLE`→`ST_LOW` when `run_i` is set.
- *release*: `ST_LOW`→`ST_WAIT_HI` once both the low count and the setup time are satisfied.
- *seen-high*: `ST_WAIT_HI`→`ST_HIGH` on a high filtered SCL.
- *next-bit*: `ST_HIGH`→`ST_LOW` when the high count ends and `run_i` is set.
- *finish*: `ST_HIGH`→`ST_IDLE` when the high count ends and `run_i` is clear.
- *disable*: any state→`ST_IDLE` whenever `en_i` is low.

Top module: `i2c_tgen`

## Requirements
- R1: With P = bits 31:28, L = bits 7:0 of the captured timing word and N the captured filter length, the SCL low phase lasts (L+1)(P+1)+N+2 kernel clocks, unless R4 makes it longer.
- R2: With H = bits 15:8, SCL stays released for N+2+(H+1)(P+1) kernel clocks, counted from the first cycle the pad reads SCL high.
- R3: With D = bits 19:16, the strobe `sda_upd_o` pulses in low-phase cycle D(P+1) (cycle 0 is the first low cycle). `sda_drive_low_o` takes the inverse of `sda_bit_i` (1 means release) one cycle later, which is D(P+1)+1 cycles after SCL fell. At no other time does it change while enabled.
- R4: With S = bits 23:20, SCL is not released until at least (S+1)(P+1) kernel clocks after that SDA change. The low phase therefore lasts max(R1 value, D(P+1)+1+(S+1)(P+1)).
- R5: The high-phase count starts only after the filtered SCL is high. A slave that holds SCL low for K extra cycles lengthens the released time by exactly K.
- R6: The filter accepts a new level only after N+1 consecutive samples that differ from the current level. A pulse of N cycles or fewer has no effect on the phase timing.
- R7: `sda_smp_o` pulses for one cycle in the first cycle of the high count. At that point `sda_filt_o` gives the filtered SDA level.
- R8: While `en_i` is low, both drive outputs are 0 from the next cycle on, and the state returns to idle. When `en_i` is set again, a fresh full low phase starts.
- R9: With `run_i` held, SCL periods follow back to back. After `run_i` clears, the current high phase completes and SCL stays released.
- R10: The timing word and filter length are captured only in idle. Changes made during a run have no effect on that run.
- R11: After reset, both drive outputs and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low releases both lines and resets the sequence |
| run_i | input | 1 | Request continuous SCL periods |
| timing_i | input | 32 | Packed timing word (prescaler, setup, hold, high, low) |
| dnf_i | input | DNF_W | Digital filter length, 0 to 16 |
| scl_i | input | 1 | SCL level read from the pad |
| sda_i | input | 1 | SDA level read from the pad |
| sda_bit_i | input | 1 | Next SDA level from the shifter (1 = release) |
| scl_drive_low_o | output | 1 | Pull SCL low |
| sda_drive_low_o | output | 1 | Pull SDA low |
| sda_upd_o | output | 1 | Strobe: shifter must present its next bit now |
| sda_smp_o | output | 1 | Strobe: SDA may be sampled now |
| sda_filt_o | output | 1 | Filtered SDA level |

## Verification
Two cases are hard to reach from the ports: a clock stretch that contains a short false release, and a low phase whose length is set by hold plus setup rather than by the low count.

The bench models a slave that keeps SCL low for a chosen number of cycles after every release. In one configuration it opens the line for two cycles inside that stretch while the filter length is three. The released time must then equal the stretch plus the unstretched high time, so an accepted glitch would show as a shorter period.

A separate configuration sets a low count of zero with large hold and setup fields. This forces the low phase to the hold-plus-setup bound.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

    localparam int TW_W = 32;
    localparam int PR_W = 4;
    localparam int DL_W = 4;
    localparam int PH_W = 8;

    // Bit layout of the packed timing word, MSB first.
    typedef struct packed {
        logic [PR_W-1:0] presc;   // 31:28
        logic [3:0]      rsvd;    // 27:24
        logic [DL_W-1:0] setup;   // 23:20
        logic [DL_W-1:0] hold;    // 19:16
        logic [PH_W-1:0] hi;      // 15:8
        logic [PH_W-1:0] lo;      // 7:0
    } tg_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } tg_state_e;

endpackage

// File: rtl/i2c_tgen_decode.sv
module i2c_tgen_decode
    import i2c_tgen_pkg::*;
#(
    parameter int DNF_W = 5,
    parameter int LEN_W = 14
) (
    input  tg_fields_t       fld_i,
    input  logic [DNF_W-1:0] dnf_i,
    output logic [LEN_W-1:0] low_len_o,
    output logic [LEN_W-1:0] high_len_o,
    output logic [LEN_W-1:0] hold_len_o,
    output logic [LEN_W-1:0] need_len_o
);

    logic [LEN_W-1:0] tick;
    logic [LEN_W-1:0] setup_len;
    logic [LEN_W-1:0] data_len;

    // All lengths in kernel clocks. The high-phase sync allowance is
    // produced by the filter latency, so it is not added here.
    always_comb begin
        tick       = LEN_W'(fld_i.presc) + LEN_W'(1);
        low_len_o  = (LEN_W'(fld_i.lo) + LEN_W'(1)) * tick
                   + LEN_W'(dnf_i) + LEN_W'(2);
        high_len_o = (LEN_W'(fld_i.hi) + LEN_W'(1)) * tick;
        hold_len_o = LEN_W'(fld_i.hold) * tick + LEN_W'(1);
        setup_len  = (LEN_W'(fld_i.setup) + LEN_W'(1)) * tick;
        data_len   = hold_len_o + setup_len;
        need_len_o = (data_len > low_len_o) ? data_len : low_len_o;
    end

endmodule

// File: rtl/i2c_tgen_glitch.sv
module i2c_tgen_glitch #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] n_i,
    input  logic             din_i,
    output logic             dout_o
);

    logic             filt_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            run_q  <= '0;
        end else if (din_i != filt_q) begin
            if (run_q >= n_i) begin
                filt_q <= din_i;
                run_q  <= '0;
            end else begin
                run_q  <= run_q + CNT_W'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

    assign dout_o = filt_q;

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(din_i) == filt_q)); // R6

endmodule

// File: rtl/i2c_tgen_cnt.sv
module i2c_tgen_cnt #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && (cnt_q != '1)) |=> (cnt_q == W'($past(cnt_q) + W'(1)))); // R1

endmodule

// File: rtl/i2c_tgen.sv
module i2c_tgen
    import i2c_tgen_pkg::*;
#(
    parameter int DNF_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             run_i,
    input  logic [TW_W-1:0]  timing_i,
    input  logic [DNF_W-1:0] dnf_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             sda_bit_i,
    output logic             scl_drive_low_o,
    output logic             sda_drive_low_o,
    output logic             sda_upd_o,
    output logic             sda_smp_o,
    output logic             sda_filt_o
);

    localparam int LEN_W    = PH_W + PR_W + 2;
    localparam int NLINE    = 2;
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    tg_state_e        state_q, state_d;
    tg_fields_t       cfg_q;
    logic [DNF_W-1:0] dnf_q;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] low_len, high_len, hold_len, need_len;
    logic [NLINE-1:0] line_raw, line_filt;
    logic             scl_filt;
    logic             sda_q;

    // Configuration capture: only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dnf_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cfg_q <= tg_fields_t'(timing_i);
            dnf_q <= dnf_i;
        end
    end

    i2c_tgen_decode #(
        .DNF_W (DNF_W),
        .LEN_W (LEN_W)
    ) u_decode (
        .fld_i      (cfg_q),
        .dnf_i      (dnf_q),
        .low_len_o  (low_len),
        .high_len_o (high_len),
        .hold_len_o (hold_len),
        .need_len_o (need_len)
    );

    // Input filters, one per bus line
    assign line_raw[LINE_SCL] = scl_i;
    assign line_raw[LINE_SDA] = sda_i;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        i2c_tgen_glitch #(
            .CNT_W (DNF_W)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .n_i    (dnf_q),
            .din_i  (line_raw[g]),
            .dout_o (line_filt[g])
        );
    end

    assign scl_filt   = line_filt[LINE_SCL];
    assign sda_filt_o = line_filt[LINE_SDA];

    // Phase counter, restarted on every state change
    i2c_tgen_cnt #(
        .W (LEN_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .inc_i (1'b1),
        .cnt_o (cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (cnt == need_len - LEN_W'(1)) state_d = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (scl_filt) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (cnt == high_len - LEN_W'(1))
                    state_d = run_i ? ST_LOW : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en_i) state_d = ST_IDLE;
    end

    // Outputs decoded from state and count
    always_comb begin
        scl_drive_low_o = (state_q == ST_LOW);
        sda_upd_o       = (state_q == ST_LOW)  && (cnt == hold_len - LEN_W'(1));
        sda_smp_o       = (state_q == ST_HIGH) && (cnt == '0);
    end

    // SDA drive register, loaded only on the hold strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sda_q <= 1'b0;
        else if (!en_i)     sda_q <= 1'b0;
        else if (sda_upd_o) sda_q <= ~sda_bit_i;
    end

    assign sda_drive_low_o = sda_q;

    AST_UPD_INSIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd_o |-> scl_drive_low_o); // R3
    AST_SDA_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sda_upd_o) |=> $stable(sda_drive_low_o)); // R3
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (cnt < need_len)); // R4
    AST_HIGH_AFTER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        sda_smp_o |-> $past(scl_filt)); // R5
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_upd_o && sda_smp_o)); // R7
    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!scl_drive_low_o && !sda_drive_low_o)); // R8

endmodule

// File: tb/sim_i2c_tgen.sv
module sim_i2c_tgen;

    localparam int CLK_PERIOD = 10;
    localparam int DNF_W      = 5;

    typedef struct {
        int    lo;
        int    hold;
        int    rel;
        int    smp;
        string lo_tag;
        string rel_tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic             run_i = 1'b0;
    logic [31:0]      timing_i = '0;
    logic [DNF_W-1:0] dnf_i = '0;
    logic             scl_i, sda_i;
    logic             sda_bit_i = 1'b0;
    logic             scl_drive_low_o, sda_drive_low_o, sda_upd_o, sda_smp_o, sda_filt_o;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];
    bit   mon_on = 1'b0;
    int   stretch_k = 0;
    bit   glitch_on = 1'b0;
    int   rel_cyc = 1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tgen #(.DNF_W(DNF_W)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_i            (en_i),
        .run_i           (run_i),
        .timing_i        (timing_i),
        .dnf_i           (dnf_i),
        .scl_i           (scl_i),
        .sda_i           (sda_i),
        .sda_bit_i       (sda_bit_i),
        .scl_drive_low_o (scl_drive_low_o),
        .sda_drive_low_o (sda_drive_low_o),
        .sda_upd_o       (sda_upd_o),
        .sda_smp_o       (sda_smp_o),
        .sda_filt_o      (sda_filt_o)
    );

    // Bus model: a slave may hold SCL low after each release
    always @(posedge clk) begin
        if (scl_drive_low_o) rel_cyc <= 0;
        else if (rel_cyc < 1000) rel_cyc <= rel_cyc + 1;
    end

    wire stretch_hold = !scl_drive_low_o && (rel_cyc < stretch_k) &&
                        !(glitch_on && (rel_cyc == 1 || rel_cyc == 2));
    assign scl_i = !(scl_drive_low_o || stretch_hold);
    assign sda_i = !sda_drive_low_o;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor / scoreboard
    int   low_cnt = 0, upd_idx = -1, chg_idx = -1, rel_cnt = 0, smp_idx = -1;
    bit   prev_low = 1'b0, prev_sda = 1'b0, pend_v = 1'b0;
    exp_t pend, cur;

    always @(negedge clk) begin
        if (!mon_on) begin
            prev_low  = scl_drive_low_o;
            prev_sda  = sda_drive_low_o;
            pend_v    = 1'b0;
            sda_bit_i = sda_drive_low_o;
        end else begin
            if (scl_drive_low_o) begin
                if (!prev_low) begin
                    if (pend_v) begin
                        chk(rel_cnt == pend.rel, pend.rel_tag, rel_cnt, pend.rel);
                        chk(smp_idx == pend.smp, "R7 sample strobe position", smp_idx, pend.smp);
                    end
                    low_cnt = 0; upd_idx = -1; chg_idx = -1;
                end
                if (sda_upd_o) upd_idx = low_cnt;
                if ((sda_drive_low_o != prev_sda) && (chg_idx < 0)) chg_idx = low_cnt;
                low_cnt++;
            end else begin
                if (prev_low) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R9 unexpected low phase", low_cnt, 0);
                        pend_v = 1'b0;
                    end else begin
                        cur = q.pop_front();
                        chk(low_cnt == cur.lo, cur.lo_tag, low_cnt, cur.lo);
                        chk(upd_idx == cur.hold - 1, "R3 hold strobe cycle", upd_idx, cur.hold - 1);
                        chk(chg_idx == cur.hold, "R3 SDA change cycle", chg_idx, cur.hold);
                        pend = cur;
                        pend_v = 1'b1;
                    end
                    rel_cnt = 0; smp_idx = -1;
                    sda_bit_i = ~sda_bit_i;
                end
                if (sda_smp_o) begin
                    smp_idx = rel_cnt;
                    chk(sda_filt_o == !sda_drive_low_o, "R7 filtered SDA at sample",
                        int'(sda_filt_o), int'(!sda_drive_low_o));
                end
                rel_cnt++;
            end
            prev_low = scl_drive_low_o;
            prev_sda = sda_drive_low_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] word(input int p, input int s, input int d,
                                         input int h, input int l);
        return {4'(p), 4'd0, 4'(s), 4'(d), 8'(h), 8'(l)};
    endfunction

    function automatic exp_t expect_of(input int p, input int l, input int h, input int d,
                                       input int s, input int n, input int k,
                                       input string lt, input string rt);
        exp_t e;
        int tk, lo, ds;
        tk = p + 1;
        lo = (l + 1) * tk + n + 2;        // R1
        e.hold = d * tk + 1;              // R3
        ds = e.hold + (s + 1) * tk;       // R4
        e.lo = (ds > lo) ? ds : lo;
        e.rel = k + n + 2 + (h + 1) * tk; // R2, R5
        e.smp = k + n + 2;                // R7
        e.lo_tag = lt;
        e.rel_tag = rt;
        return e;
    endfunction

    task automatic run_cfg(input int p, input int l, input int h, input int d, input int s,
                           input int n, input int k, input bit gl, input bit chg,
                           input string lt, input string rt);
        exp_t e;
        e = expect_of(p, l, h, d, s, n, k, lt, rt);
        for (int i = 0; i < 3; i++) q.push_back(e);
        timing_i  = word(p, s, d, h, l);
        dnf_i     = DNF_W'(n);
        stretch_k = k;
        glitch_on = gl;
        step(1);
        mon_on = 1'b1;
        run_i  = 1'b1;
        if (chg) begin
            step(2);
            timing_i = word(2, 0, 0, 3, 1);   // R10: must not affect this run
            dnf_i    = DNF_W'(16);
        end
        while (q.size() != 0) @(negedge clk);
        #1;
        run_i = 1'b0;
        step(80);
        chk(scl_drive_low_o == 1'b0, "R9 SCL released after run ends", int'(scl_drive_low_o), 0);
        mon_on = 1'b0;
        stretch_k = 0;
        glitch_on = 1'b0;
        step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        step(3);
        chk(scl_drive_low_o == 1'b0, "R11 reset SCL drive", int'(scl_drive_low_o), 0);
        chk(sda_drive_low_o == 1'b0, "R11 reset SDA drive", int'(sda_drive_low_o), 0);
        chk(sda_upd_o == 1'b0 && sda_smp_o == 1'b0, "R11 reset strobes",
            int'({sda_upd_o, sda_smp_o}), 0);
        rst_n = 1'b1;
        step(2);
        en_i = 1'b1;
        step(2);

        // R1/R2 basic, with a mid-run word change (R10)
        run_cfg(0, 3, 2, 1, 0, 0, 0, 1'b0, 1'b1, "R10 R1 low length", "R2 released length");
        // R1/R2 with prescaler and filter
        run_cfg(1, 2, 1, 2, 1, 3, 0, 1'b0, 1'b0, "R1 low length prescaled", "R2 released length prescaled");
        // R4 setup-dominated low phase
        run_cfg(0, 0, 0, 7, 9, 0, 0, 1'b0, 1'b0, "R4 low length from hold+setup", "R2 minimal high");
        // R5 clock stretch
        run_cfg(0, 3, 2, 1, 0, 0, 4, 1'b0, 1'b0, "R1 low length", "R5 stretched release");
        // Large filter
        run_cfg(2, 1, 3, 0, 0, 16, 0, 1'b0, 1'b0, "R1 low length max filter", "R2 released length max filter");
        // R6 glitch inside a stretch
        run_cfg(1, 2, 1, 2, 1, 3, 6, 1'b1, 1'b0, "R1 low length", "R6 glitch rejected");

        // R8 disable mid phase, then restart
        timing_i = word(1, 1, 2, 1, 2);
        dnf_i    = DNF_W'(3);
        step(1);
        run_i = 1'b1;
        step(4);
        en_i = 1'b0;
        step(1);
        chk(scl_drive_low_o == 1'b0, "R8 SCL released on disable", int'(scl_drive_low_o), 0);
        chk(sda_drive_low_o == 1'b0, "R8 SDA released on disable", int'(sda_drive_low_o), 0);
        step(3);
        chk(scl_drive_low_o == 1'b0, "R8 SCL stays released", int'(scl_drive_low_o), 0);
        begin
            exp_t e;
            e = expect_of(1, 2, 1, 2, 1, 3, 0, "R8 full low phase after re-enable", "R8 release after re-enable");
            q.push_back(e);
            q.push_back(e);
        end
        mon_on = 1'b1;
        en_i   = 1'b1;
        while (q.size() != 0) @(negedge clk);
        #1;
        run_i = 1'b0;
        step(80);
        chk(scl_drive_low_o == 1'b0, "R9 idle after final period", int'(scl_drive_low_o), 0);
        mon_on = 1'b0;
        step(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule